// File: doc/BRIEF.md
# UART Transmit Queue and Request Controller

This block is the host-facing transmit store of one serial channel. The host pushes bytes through a write port. A separate serial shift engine pulls them from a pop port in arrival order. When queue mode is on, the store is a 64-entry FIFO. When it is off, the store is a single holding register. The block reports the free-slot count, a holding-empty flag and a transmitter-idle flag.

It also decides when to ask the host for more data, on two outputs. The first is a transmit-ready interrupt. It follows a programmable free-slot threshold. Once the host services it, it stays quiet until the host has written two more bytes. The second is a DMA request. In burst mode it rises above the threshold and holds until the queue is full. In single-transfer mode it simply flags an empty store.

Top module: `uart_txq_ctrl`

## Requirements
- R1: Bytes leave the pop port in the order they were accepted. `pop_valid` is high in a cycle only when `pop_req` is high and the store holds data. `pop_data` then shows the oldest byte. A push and a pop may occur in the same cycle.
- R2: Capacity is DEPTH (64) with `fifo_en` high and 1 with it low. A write that arrives while the store is full is dropped. A pop request on an empty store gives `pop_valid` low and changes nothing.
- R3: `space` equals capacity minus stored bytes. After reset the store is empty in single mode, so `space` is 1 and `dma_req` is 1.
- R4: In queue mode `hold_empty` is high when `space` is strictly greater than the threshold picked by `thr_sel`. The encodings are 0 for 8, 1 for 16, 2 for 32 and 3 for 56. In single mode `hold_empty` is high when the register is empty.
- R5: `tx_empty` is high exactly when the store is empty and `shifter_busy` is low.
- R6: An interrupt becomes pending on the clock edge after `hold_empty` is seen high while the interrupt is armed. `tx_irq` is that pending state gated by `int_en`.
- R7: While `tx_irq` is high, a host write (`wr_en`) or an interrupt-identity read (`iir_rd`) services it. `tx_irq` is then low from the next cycle, and the interrupt is disarmed.
- R8: In queue mode a disarmed interrupt re-arms on the edge of the second write accepted after servicing. A servicing write counts as the first of the two. In single mode the interrupt is always armed.
- R9: With `dma_mode` high in queue mode, `dma_req` rises on the edge after `space` exceeds the threshold. It then stays high until `space` reaches 0, and stays low until `space` again exceeds the threshold.
- R10: With `dma_mode` low, or in single mode, `dma_req` is high exactly while the store is empty.
- R11: A change of `fifo_en` flushes the store in the cycle it is seen. That cycle accepts no write and no pop. The interrupt re-arms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single holding register |
| dma_mode | input | 1 | 1 selects burst DMA request behaviour |
| thr_sel | input | 2 | Free-slot threshold select |
| int_en | input | 1 | Transmit-ready interrupt enable |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| iir_rd | input | 1 | Host read of the interrupt identity |
| pop_req | input | 1 | Shift engine requests a byte |
| pop_data | output | 8 | Oldest stored byte |
| pop_valid | output | 1 | Pop accepted this cycle |
| shifter_busy | input | 1 | Shift engine still holds a character |
| space | output | 7 | Free slots |
| hold_empty | output | 1 | Holding/queue empty status |
| tx_empty | output | 1 | Store and shifter both empty |
| tx_irq | output | 1 | Transmit-ready interrupt |
| dma_req | output | 1 | DMA request |

## Verification
A corrupted occupancy count shows up at once on `space`, `hold_empty`, `tx_empty` and the single-transfer `dma_req`. These are combinational from the count, so the bench sees the fault in the same cycle it appears. A bad pointer is only exposed when a later pop returns the wrong byte. A wrong armed or pending bit shows up as `tx_irq` firing or staying silent one cycle later than the reference model expects. A lost burst-request bit appears on `dma_req` as a drop partway through a refill.

// File: rtl/uart_txq_ctrl.sv
module uart_txq_ctrl #(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fifo_en,
  input  logic                     dma_mode,
  input  logic [1:0]               thr_sel,
  input  logic                     int_en,
  input  logic                     wr_en,
  input  logic [7:0]               wr_data,
  input  logic                     iir_rd,
  input  logic                     pop_req,
  output logic [7:0]               pop_data,
  output logic                     pop_valid,
  input  logic                     shifter_busy,
  output logic [$clog2(DEPTH):0]   space,
  output logic                     hold_empty,
  output logic                     tx_empty,
  output logic                     tx_irq,
  output logic                     dma_req
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count, cap, thr;
  logic          mode, flush, full, wr_acc, pend, armed, wseen, dreq, service;

  assign flush     = fifo_en != mode;
  assign cap       = mode ? CW'(DEPTH) : CW'(1);
  assign full      = count == cap;
  assign wr_acc    = wr_en && !full && !flush;
  assign pop_valid = pop_req && (count != '0) && !flush;
  assign pop_data  = mem[rptr];
  assign space     = cap - count;

  always_comb begin
    if (!mode) thr = '0;
    else begin
      case (thr_sel)
        2'd0:    thr = CW'(DEPTH / 8);
        2'd1:    thr = CW'(DEPTH / 4);
        2'd2:    thr = CW'(DEPTH / 2);
        default: thr = CW'(DEPTH - DEPTH / 8);
      endcase
    end
  end

  assign hold_empty = space > thr;
  assign tx_empty   = (count == '0) && !shifter_busy;
  assign tx_irq     = pend && int_en;
  assign service    = tx_irq && (wr_en || iir_rd);
  assign dma_req    = (dma_mode && mode) ? dreq : (count == '0);

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= 1'b0;
      count <= '0;
      wptr  <= '0;
      rptr  <= '0;
      pend  <= 1'b0;
      armed <= 1'b1;
      wseen <= 1'b0;
      dreq  <= 1'b0;
    end else begin
      pend <= !service && hold_empty && (pend || armed || !mode);
      if (space > thr)        dreq <= 1'b1;
      else if (space == '0)   dreq <= 1'b0;
      if (flush) begin
        mode  <= fifo_en;
        count <= '0;
        wptr  <= '0;
        rptr  <= '0;
        armed <= 1'b1;
        wseen <= 1'b0;
      end else begin
        count <= count + CW'(wr_acc) - CW'(pop_valid);
        if (wr_acc)    wptr <= wptr + 1'b1;
        if (pop_valid) rptr <= rptr + 1'b1;
        if (service) begin
          armed <= 1'b0;
          wseen <= wr_acc;
        end else if (!armed && wr_acc) begin
          if (wseen) begin
            armed <= 1'b1;
            wseen <= 1'b0;
          end else begin
            wseen <= 1'b1;
          end
        end
      end
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cap);
  p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !pop_valid && !flush) |=> $stable(count));
  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> hold_empty);
  p_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && iir_rd) |=> !tx_irq);
  p_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !flush && !armed && !wr_acc) |=> !armed);
  p_dma_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && space != '0) |=> dreq);
  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
endmodule

// File: tb/uart_txq_ctrl_test.sv
`timescale 1ns/1ps
module uart_txq_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic fifo_en = 0, dma_mode = 0, int_en = 0, wr_en = 0, iir_rd = 0, pop_req = 0, shifter_busy = 0;
  logic [1:0] thr_sel = 0;
  logic [7:0] wr_data = 0, pop_data;
  logic pop_valid, hold_empty, tx_empty, tx_irq, dma_req;
  logic [6:0] space;
  int vec = 0, errs = 0;

  uart_txq_ctrl uut (.clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_mode(dma_mode),
    .thr_sel(thr_sel), .int_en(int_en), .wr_en(wr_en), .wr_data(wr_data), .iir_rd(iir_rd),
    .pop_req(pop_req), .pop_data(pop_data), .pop_valid(pop_valid), .shifter_busy(shifter_busy),
    .space(space), .hold_empty(hold_empty), .tx_empty(tx_empty), .tx_irq(tx_irq), .dma_req(dma_req));

  always #2.5 clk = ~clk;

  byte unsigned q[$];
  bit m_mode = 0, m_pend = 0, m_armed = 1, m_wseen = 0, m_dreq = 0;

  function automatic int thr_of(bit md, logic [1:0] s);
    if (!md) return 0;
    case (s) 2'd0: return 8; 2'd1: return 16; 2'd2: return 32; default: return 56; endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    vec++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_mode = 0; m_pend = 0; m_armed = 1; m_wseen = 0; m_dreq = 0;
    end else begin
      int cnt, cp, sp, th;
      bit fl, acc, pv, he, irq, svc;
      cnt = q.size(); cp = m_mode ? 64 : 1; sp = cp - cnt; th = thr_of(m_mode, thr_sel);
      fl = fifo_en != m_mode;
      acc = wr_en && cnt != cp && !fl;
      pv = pop_req && cnt != 0 && !fl;
      he = sp > th; irq = m_pend && int_en; svc = irq && (wr_en || iir_rd);
      m_pend = !svc && he && (m_pend || m_armed || !m_mode);
      if (sp > th) m_dreq = 1; else if (sp == 0) m_dreq = 0;
      if (fl) begin
        q.delete(); m_mode = fifo_en; m_armed = 1; m_wseen = 0;
      end else begin
        if (pv) void'(q.pop_front());
        if (acc) q.push_back(wr_data);
        if (svc) begin m_armed = 0; m_wseen = acc; end
        else if (!m_armed && acc) begin
          if (m_wseen) begin m_armed = 1; m_wseen = 0; end else m_wseen = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int cnt, cp, sp, th;
      bit pv;
      cnt = q.size(); cp = m_mode ? 64 : 1; sp = cp - cnt; th = thr_of(m_mode, thr_sel);
      pv = pop_req && cnt != 0 && (fifo_en == m_mode);
      chk("R3 space", space, sp);
      chk("R4 hold_empty", hold_empty, sp > th);
      chk("R5 tx_empty", tx_empty, cnt == 0 && !shifter_busy);
      chk("R6 tx_irq", tx_irq, m_pend && int_en);
      if (dma_mode && m_mode) chk("R9 dma_req", dma_req, m_dreq);
      else chk("R10 dma_req", dma_req, cnt == 0);
      chk("R1 pop_valid", pop_valid, pv);
      if (pv) chk("R1 pop_data", pop_data, q[0]);
    end
  end

  task automatic go(bit w, logic [7:0] d, bit p, bit r);
    @(posedge clk); #1;
    wr_en = w; wr_data = d; pop_req = p; iir_rd = r;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) go(0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R3 reset space", space, 1);
    chk("R3 reset dma_req", dma_req, 1);
    chk("R3 reset tx_irq", tx_irq, 0);
    int_en = 1;
    go(1, 8'hA5, 0, 0); go(1, 8'h5A, 0, 0); idle(1);
    @(negedge clk); chk("R2 single full drop", space, 0);
    go(0, 0, 1, 0); go(0, 0, 1, 0); idle(2);
    @(posedge clk); #1 fifo_en = 1;
    idle(3);
    @(negedge clk); chk("R11 flush space", space, 64);
    chk("R11 rearm irq", tx_irq, 1);
    thr_sel = 2'd3;
    go(0, 0, 0, 1); idle(1);
    @(negedge clk); chk("R7 service by read", tx_irq, 0);
    go(1, 8'h11, 0, 0); idle(2);
    @(negedge clk); chk("R8 one write no irq", tx_irq, 0);
    go(1, 8'h22, 0, 0); idle(2);
    @(negedge clk); chk("R8 rearm after two", tx_irq, 1);
    go(1, 8'h33, 0, 0); idle(1);
    @(negedge clk); chk("R7 service by write", tx_irq, 0);
    dma_mode = 1;
    for (int i = 0; i < 70; i++) go(1, 8'(i * 7 + 3), 0, 0);
    idle(2);
    @(negedge clk); chk("R2 full space", space, 0);
    chk("R9 dma low at full", dma_req, 0);
    for (int i = 0; i < 70; i++) begin
      thr_sel = 2'(i / 16);
      shifter_busy = i[2];
      go(0, 0, 1, 0);
    end
    idle(2);
    shifter_busy = 0;
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (i == 200) dma_mode = 0;
      thr_sel = lf[9:8];
      int_en = lf[7] | lf[6];
      go(lf[0] | lf[1], lf[15:8], lf[2] & lf[3], lf[4] & lf[5]);
    end
    for (int i = 0; i < 20; i++) go(1, 8'(i), 0, 0);
    @(posedge clk); #1 fifo_en = 0; wr_en = 0;
    idle(2);
    @(negedge clk); chk("R11 flush to single", space, 1);
    chk("R10 empty after flush", dma_req, 1);
    go(1, 8'h77, 0, 0); idle(1);
    @(negedge clk); chk("R10 dma low after write", dma_req, 0);
    go(0, 0, 1, 0); go(0, 0, 1, 0); idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end
endmodule